// File: doc/BRIEF.md
# PHY Management Register Bank

This block models the register side of an Ethernet PHY's management interface. It holds sixteen 16-bit registers: basic control, basic status, two identifier words, the local ability advertisement, the link partner ability word and ten general registers. A MAC-side management agent reaches them through parallel strobes. Each access carries a PHY address and a register address. Only accesses aimed at the block's own PHY address take effect. The serial management framing is handled elsewhere.

A `link_up` input is sampled every clock. It drives the link bit in the status word and the partner ability bits in register 5. Setting the self-clearing reset bit in the control word puts every register back to its power-on value. The current link state is then applied over those values. Reads are registered: the data and a one-cycle valid pulse appear on the clock after the read strobe.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset with `link_up` low, a read of register 0 returns 0x1000, register 1 returns 0x7848, register 2 returns 0x2000, register 3 returns 0x5C90, register 4 returns 0x01E1, and registers 5 to 15 return 0x0000.
- R2: A write to register 0 with bit 15 clear stores the written word, and later reads return it.
- R3: A write to register 0 with bit 15 set stores nothing. Instead, every register returns to its R1 value, with the R6 link overlay applied.
- R4: Writes to registers 1, 2 and 3 leave their contents unchanged.
- R5: On the first clock where `link_up` differs from its value on the previous clock, the link state is applied to registers 1 and 5. Link up sets status bit 2 and ORs 0x01E1 into register 5. Link down clears status bit 2 and ANDs register 5 with 0x01FF.
- R6: Both the reset input and the soft reset of R3 apply the R5 overlay using the `link_up` value of that clock. With the link up, this gives status 0x784C and register 5 0x01E1.
- R7: Accesses with a PHY address other than `PHY_ADDR` (default 1) leave all registers unchanged. A read with such an address returns 0xFFFF.
- R8: With the PHY address matching, a write to a register address of 16 or more changes nothing, and a read of such an address returns 0x0000.
- R9: `rd_valid` is high for exactly the clock after each cycle with `rd_en` high, and low otherwise. `rd_data` then holds the register contents as they stood before any write in the same cycle as the read strobe.
- R10: Registers 4 to 15 store host writes as plain data. If a link change falls in the same cycle as a write to register 5, the R5 overlay is applied on top of the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_phy | input | ADDR_W | PHY address of the write |
| wr_reg | input | ADDR_W | Register address of the write |
| wr_data | input | DATA_W | Word to write |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_phy | input | ADDR_W | PHY address of the read |
| rd_reg | input | ADDR_W | Register address of the read |
| rd_data | output | DATA_W | Read result, valid with rd_valid |
| rd_valid | output | 1 | One-cycle pulse marking rd_data |
| link_up | input | 1 | Link state, sampled every clock |

## Verification
Two events can land on register 5 in the same clock: a host write and a link transition. The bench drives `link_up` low in the same cycle that it writes 0xFFFF to register 5. It then requires 0x01FF, which shows the written word stored and then masked by the link-down overlay. A second collision issues a read and a write to the same register together. The bench requires the old contents on that read and the new contents on the next read.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

    localparam int MGMT_AW   = 5;
    localparam int MGMT_DW   = 16;
    localparam int MGMT_NREG = 16;
    localparam int MGMT_IXW  = $clog2(MGMT_NREG);

    // register indices with special behaviour
    localparam int IX_CTRL    = 0;
    localparam int IX_STAT    = 1;
    localparam int IX_ID_HI   = 2;
    localparam int IX_ID_LO   = 3;
    localparam int IX_ADV     = 4;
    localparam int IX_PARTNER = 5;

    localparam int CTRL_RST_POS  = 15;
    localparam int STAT_LINK_POS = 2;

    localparam logic [MGMT_DW-1:0] PARTNER_UP_SET    = 16'h01E1;
    localparam logic [MGMT_DW-1:0] PARTNER_DOWN_KEEP = 16'h01FF;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_REG,
        ACC_FOREIGN,
        ACC_OUTSIDE
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e           kind;
        logic [MGMT_IXW-1:0] idx;
    } acc_t;

    function automatic logic [MGMT_DW-1:0] reg_default(input int i);
        case (i)
            IX_CTRL:  return 16'h1000;
            IX_STAT:  return 16'h7848;
            IX_ID_HI: return 16'h2000;
            IX_ID_LO: return 16'h5C90;
            IX_ADV:   return 16'h01E1;
            default:  return '0;
        endcase
    endfunction

    function automatic logic [MGMT_DW-1:0] link_overlay(
        input logic [MGMT_DW-1:0] v,
        input int                 i,
        input logic               up
    );
        logic [MGMT_DW-1:0] r;
        r = v;
        if (i == IX_STAT) begin
            r[STAT_LINK_POS] = up;
        end else if (i == IX_PARTNER) begin
            r = up ? (v | PARTNER_UP_SET) : (v & PARTNER_DOWN_KEEP);
        end
        return r;
    endfunction

endpackage

// File: rtl/phy_mgmt_decode.sv
module phy_mgmt_decode
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W   = MGMT_AW,
    parameter int NREG     = MGMT_NREG,
    parameter int PHY_ADDR = 1
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] phy,
    input  logic [ADDR_W-1:0] ra,
    output acc_t              acc
);

    localparam int IX_W = $clog2(NREG);
    localparam logic [ADDR_W-1:0] OWN_PHY = PHY_ADDR[ADDR_W-1:0];
    localparam logic [ADDR_W:0]   REG_LIM = NREG[ADDR_W:0];

    always_comb begin
        acc.idx = ra[IX_W-1:0];
        if (!en) begin
            acc.kind = ACC_NONE;
        end else if (phy != OWN_PHY) begin
            acc.kind = ACC_FOREIGN;
        end else if ({1'b0, ra} >= REG_LIM) begin
            acc.kind = ACC_OUTSIDE;
        end else begin
            acc.kind = ACC_REG;
        end
    end

endmodule

// File: rtl/phy_mgmt_bank.sv
module phy_mgmt_bank
    import phy_mgmt_pkg::*;
#(
    parameter int NREG = MGMT_NREG
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      link_up,
    input  acc_t                      wr,
    input  logic [MGMT_DW-1:0]        wr_data,
    output logic [NREG*MGMT_DW-1:0]   regs_flat
);

    logic [MGMT_DW-1:0] regs_q [NREG];
    logic [MGMT_DW-1:0] regs_d [NREG];
    logic               link_q;
    logic               soft_rst;
    logic               wr_hit;

    always_comb begin
        wr_hit   = (wr.kind == ACC_REG);
        soft_rst = wr_hit && (int'(wr.idx) == IX_CTRL) && wr_data[CTRL_RST_POS];

        for (int i = 0; i < NREG; i++) begin
            regs_d[i] = regs_q[i];
        end

        if (wr_hit && !soft_rst) begin
            case (int'(wr.idx))
                IX_STAT, IX_ID_HI, IX_ID_LO: ;
                default: regs_d[wr.idx] = wr_data;
            endcase
        end

        if (soft_rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_d[i] = link_overlay(reg_default(i), i, link_up);
            end
        end else if (link_up != link_q) begin
            for (int i = 0; i < NREG; i++) begin
                regs_d[i] = link_overlay(regs_d[i], i, link_up);
            end
        end
    end

    always_ff @(posedge clk) begin
        link_q <= link_up;
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= link_overlay(reg_default(i), i, link_up);
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_flat[g*MGMT_DW +: MGMT_DW] = regs_q[g];
    end

endmodule

// File: rtl/phy_mgmt_rdport.sv
module phy_mgmt_rdport
    import phy_mgmt_pkg::*;
#(
    parameter int NREG = MGMT_NREG
) (
    input  logic                    clk,
    input  logic                    rst,
    input  acc_t                    rd,
    input  logic [NREG*MGMT_DW-1:0] regs_flat,
    output logic [MGMT_DW-1:0]      rd_data,
    output logic                    rd_valid
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (rd.kind != ACC_NONE);
            case (rd.kind)
                ACC_REG:     rd_data <= regs_flat[int'(rd.idx)*MGMT_DW +: MGMT_DW];
                ACC_FOREIGN: rd_data <= '1;
                ACC_OUTSIDE: rd_data <= '0;
                default:     rd_data <= rd_data;
            endcase
        end
    end

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
    import phy_mgmt_pkg::*;
#(
    parameter int ADDR_W   = MGMT_AW,
    parameter int DATA_W   = MGMT_DW,
    parameter int PHY_ADDR = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_phy,
    input  logic [ADDR_W-1:0] wr_reg,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_phy,
    input  logic [ADDR_W-1:0] rd_reg,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              link_up
);

    localparam int NREG = MGMT_NREG;

    acc_t                     wr_acc;
    acc_t                     rd_acc;
    logic [NREG*DATA_W-1:0]   regs_flat;

    phy_mgmt_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .PHY_ADDR(PHY_ADDR)) i_wr_dec (
        .en  (wr_en),
        .phy (wr_phy),
        .ra  (wr_reg),
        .acc (wr_acc)
    );

    phy_mgmt_decode #(.ADDR_W(ADDR_W), .NREG(NREG), .PHY_ADDR(PHY_ADDR)) i_rd_dec (
        .en  (rd_en),
        .phy (rd_phy),
        .ra  (rd_reg),
        .acc (rd_acc)
    );

    phy_mgmt_bank #(.NREG(NREG)) i_bank (
        .clk       (clk),
        .rst       (rst),
        .link_up   (link_up),
        .wr        (wr_acc),
        .wr_data   (wr_data),
        .regs_flat (regs_flat)
    );

    phy_mgmt_rdport #(.NREG(NREG)) i_rdport (
        .clk       (clk),
        .rst       (rst),
        .rd        (rd_acc),
        .regs_flat (regs_flat),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid)
    );

endmodule

// File: rtl/phy_mgmt_chk.sv
module phy_mgmt_chk
    import phy_mgmt_pkg::*;
#(
    parameter int PHY_ADDR = 1
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic [MGMT_AW-1:0]           wr_phy,
    input logic [MGMT_AW-1:0]           wr_reg,
    input logic [MGMT_DW-1:0]           wr_data,
    input logic                         rd_en,
    input logic [MGMT_AW-1:0]           rd_phy,
    input logic                         link_up,
    input logic [MGMT_DW-1:0]           rd_data,
    input logic                         rd_valid,
    input logic [MGMT_NREG*MGMT_DW-1:0] regs_flat
);

    localparam logic [MGMT_AW-1:0] OWN = PHY_ADDR[MGMT_AW-1:0];

    // R9: a read strobe is answered on the next clock
    p_valid_after_read_r9: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R9: no pulse without a strobe
    p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R7: foreign PHY address reads all ones
    p_foreign_ones_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_phy != OWN) |=> rd_data == 16'hFFFF);

    // R5: status link bit tracks the link sampled one clock earlier
    p_status_link_r5: assert property (@(posedge clk) disable iff (rst)
        !rst |=> regs_flat[IX_STAT*MGMT_DW + STAT_LINK_POS] == $past(link_up));

    // R3: soft reset leaves control at its default
    p_soft_reset_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_phy == OWN && wr_reg == 5'd0 && wr_data[CTRL_RST_POS])
        |=> regs_flat[MGMT_DW-1:0] == 16'h1000);

    // R4: identifier words ignore writes
    p_id_stable_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_reg == 5'd2 || wr_reg == 5'd3))
        |=> $stable(regs_flat[4*MGMT_DW-1:2*MGMT_DW]));

    // R8: out-of-range writes change nothing while the link is steady
    p_outside_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_reg[MGMT_AW-1] && link_up == $past(link_up))
        |=> $stable(regs_flat));

endmodule

bind phy_mgmt_regfile phy_mgmt_chk #(.PHY_ADDR(PHY_ADDR)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_phy    (wr_phy),
    .wr_reg    (wr_reg),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_phy    (rd_phy),
    .link_up   (link_up),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .regs_flat (regs_flat)
);

// File: tb/test_phy_mgmt_regfile.sv
module test_phy_mgmt_regfile;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en, link_up;
    logic [4:0]  wr_phy, wr_reg, rd_phy, rd_reg;
    logic [15:0] wr_data, rd_data;
    logic        rd_valid;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    phy_mgmt_regfile i_phy_mgmt_regfile (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_phy(wr_phy), .wr_reg(wr_reg), .wr_data(wr_data),
        .rd_en(rd_en), .rd_phy(rd_phy), .rd_reg(rd_reg),
        .rd_data(rd_data), .rd_valid(rd_valid), .link_up(link_up)
    );

    // {req[46:43], is_read[42], phy[41:37], reg[36:32], data[31:16], expect[15:0]}
    localparam int NVEC = 27;
    localparam logic [46:0] VEC [NVEC] = '{
        {4'd1,  1'b1, 5'd1, 5'd0,  16'h0000, 16'h1000},  // R1
        {4'd1,  1'b1, 5'd1, 5'd1,  16'h0000, 16'h7848},  // R1
        {4'd1,  1'b1, 5'd1, 5'd2,  16'h0000, 16'h2000},  // R1
        {4'd1,  1'b1, 5'd1, 5'd3,  16'h0000, 16'h5C90},  // R1
        {4'd1,  1'b1, 5'd1, 5'd4,  16'h0000, 16'h01E1},  // R1
        {4'd1,  1'b1, 5'd1, 5'd5,  16'h0000, 16'h0000},  // R1
        {4'd1,  1'b1, 5'd1, 5'd9,  16'h0000, 16'h0000},  // R1
        {4'd2,  1'b0, 5'd1, 5'd0,  16'h1140, 16'h0000},  // R2
        {4'd2,  1'b1, 5'd1, 5'd0,  16'h0000, 16'h1140},  // R2
        {4'd4,  1'b0, 5'd1, 5'd1,  16'hFFFF, 16'h0000},  // R4
        {4'd4,  1'b1, 5'd1, 5'd1,  16'h0000, 16'h7848},  // R4
        {4'd4,  1'b0, 5'd1, 5'd2,  16'h1234, 16'h0000},  // R4
        {4'd4,  1'b1, 5'd1, 5'd2,  16'h0000, 16'h2000},  // R4
        {4'd4,  1'b0, 5'd1, 5'd3,  16'h4321, 16'h0000},  // R4
        {4'd4,  1'b1, 5'd1, 5'd3,  16'h0000, 16'h5C90},  // R4
        {4'd10, 1'b0, 5'd1, 5'd4,  16'h0DE1, 16'h0000},  // R10
        {4'd10, 1'b1, 5'd1, 5'd4,  16'h0000, 16'h0DE1},  // R10
        {4'd10, 1'b0, 5'd1, 5'd9,  16'hABCD, 16'h0000},  // R10
        {4'd10, 1'b1, 5'd1, 5'd9,  16'h0000, 16'hABCD},  // R10
        {4'd7,  1'b0, 5'd2, 5'd9,  16'h5555, 16'h0000},  // R7
        {4'd7,  1'b1, 5'd1, 5'd9,  16'h0000, 16'hABCD},  // R7
        {4'd7,  1'b1, 5'd0, 5'd0,  16'h0000, 16'hFFFF},  // R7
        {4'd8,  1'b0, 5'd1, 5'd20, 16'h7777, 16'h0000},  // R8
        {4'd8,  1'b1, 5'd1, 5'd20, 16'h0000, 16'h0000},  // R8
        {4'd8,  1'b1, 5'd1, 5'd4,  16'h0000, 16'h0DE1},  // R8
        {4'd10, 1'b0, 5'd1, 5'd5,  16'hFE00, 16'h0000},  // R10
        {4'd10, 1'b1, 5'd1, 5'd5,  16'h0000, 16'hFE00}   // R10
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
        wr_en = 1'b1; wr_phy = phy; wr_reg = ra; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] exp);
        rd_en = 1'b1; rd_phy = phy; rd_reg = ra;
        tick();
        rd_en = 1'b0;
        check(9, {15'd0, rd_valid}, 16'd1);   // R9 pulse accompanies data
        check(req, rd_data, exp);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; link_up = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0;
        wr_phy = '0; wr_reg = '0; wr_data = '0; rd_phy = '0; rd_reg = '0;
        @(negedge clk);
        tick(); tick();
        rst = 1'b0;
        tick();
        check(9, {15'd0, rd_valid}, 16'd0);   // R9 no pulse after reset

        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][42])
                do_read(int'(VEC[k][46:43]), VEC[k][41:37], VEC[k][36:32], VEC[k][15:0]);
            else
                do_write(VEC[k][41:37], VEC[k][36:32], VEC[k][31:16]);
        end
        tick();
        check(9, {15'd0, rd_valid}, 16'd0);   // R9 idle cycle drops valid

        // R5 link rising
        link_up = 1'b1; tick();
        do_read(5, 5'd1, 5'd1, 16'h784C);
        do_read(5, 5'd1, 5'd5, 16'hFFE1);
        // R5 link falling
        link_up = 1'b0; tick();
        do_read(5, 5'd1, 5'd1, 16'h7848);
        do_read(5, 5'd1, 5'd5, 16'h01E1);

        // R3 / R6 soft reset with link up
        link_up = 1'b1; tick();
        do_write(5'd1, 5'd0, 16'h8000);
        do_read(3, 5'd1, 5'd0, 16'h1000);
        do_read(3, 5'd1, 5'd9, 16'h0000);
        do_read(3, 5'd1, 5'd4, 16'h01E1);
        do_read(6, 5'd1, 5'd1, 16'h784C);
        do_read(6, 5'd1, 5'd5, 16'h01E1);

        // R10 write to register 5 and link fall in the same cycle
        link_up = 1'b0;
        do_write(5'd1, 5'd5, 16'hFFFF);
        do_read(10, 5'd1, 5'd5, 16'h01FF);
        do_read(5, 5'd1, 5'd1, 16'h7848);

        // R9 read and write of one register in the same cycle
        wr_en = 1'b1; wr_phy = 5'd1; wr_reg = 5'd9; wr_data = 16'h1111;
        rd_en = 1'b1; rd_phy = 5'd1; rd_reg = 5'd9;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
        check(9, rd_data, 16'h0000);
        do_read(9, 5'd1, 5'd9, 16'h1111);

        // R6 hardware reset while link is up
        link_up = 1'b1;
        rst = 1'b1; tick(); tick();
        rst = 1'b0; tick();
        do_read(6, 5'd1, 5'd1, 16'h784C);
        do_read(6, 5'd1, 5'd5, 16'h01E1);
        do_read(1, 5'd1, 5'd9, 16'h0000);
        do_read(1, 5'd1, 5'd0, 16'h1000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule